// File: doc/BRIEF.md
# Dual-Engine In-Order GCD Coprocessor

This block computes the greatest common divisor of unsigned operand pairs using two identical iterative engines that run side by side. A pair is handed in through a valid/ready request port, goes to whichever engine can take it, and its result comes back through a valid/ready response port. Two long computations can therefore overlap, which roughly halves the time a stream of similar jobs needs compared with a single engine.

Results always leave in the order their requests were accepted. A single bit of state names the engine that holds the oldest job still owed to the consumer. Only that engine's result is offered on the response port. A younger job that finishes early stays parked in its engine until the older one has been delivered. Everything else in the steering and response path is combinational.

Each engine works by repeated subtraction. It takes the smaller operand away from the larger one, swaps the two when the first has become the smaller, and stops as soon as the second operand is zero. The first operand is then the answer.

Top module: `gcd_dual_top`

## Requirements
- R1: When synchronous active-high `rst` has been released, `resp_valid` is 0 and `req_ready` is 1.
- R2: Each response value equals the greatest common divisor of its pair, with gcd(0,x)=x, gcd(x,0)=x and gcd(0,0)=0.
- R3: Responses come out in the order their requests were accepted, including when a later job finishes before an earlier one.
- R4: While exactly one accepted job is still owed a response, `req_ready` stays 1, so a second job can start while the first is still being computed.
- R5: While two accepted jobs are still owed responses, `req_ready` is 0. A further request waits until the older job has been delivered.
- R6: While `resp_valid` is 1 and `resp_ready` is 0, `resp_valid` stays 1 and `resp_gcd` does not change on the next cycle.
- R7: A burst of eight jobs that each need about 1000 subtraction steps completes in fewer than 65% of the cycles that one engine would need for the same subtraction work.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Operand pair offered |
| req_ready | output | 1 | An engine can take a pair this cycle |
| req_a | input | W | First operand |
| req_b | input | W | Second operand |
| resp_valid | output | 1 | Oldest outstanding result available |
| resp_ready | input | 1 | Consumer takes the result |
| resp_gcd | output | W | Result value |

## Verification
The hardest case to reach is a younger job that completes while an older, slower job still occupies the other engine. That job's result must be held back, and request ready must drop because both engines are occupied. The stimulus starts with a pair that needs about a thousand subtraction steps and follows it at once with a pair that needs only a few. A third pair is then offered straight away, so it has to wait until the slow result has been delivered. A separate phase holds the response port stalled on a finished result, to show that the result is held steady.

// File: rtl/gcd_dual_pkg.sv
package gcd_dual_pkg;
    localparam int NUM_ENG = 2;

    typedef enum logic [1:0] {
        ENG_IDLE = 2'd0,
        ENG_RUN  = 2'd1,
        ENG_DONE = 2'd2
    } eng_mode_e;

    typedef struct packed {
        logic oldest;
    } arb_state_t;
endpackage

// File: rtl/gcd_engine.sv
module gcd_engine
    import gcd_dual_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         take,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic         free,
    output logic         done,
    output logic [W-1:0] result
);
    typedef struct packed {
        eng_mode_e    mode;
        logic [W-1:0] x;
        logic [W-1:0] y;
    } eng_state_t;

    eng_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.mode)
            ENG_IDLE: begin
                if (start) begin
                    st_d.x    = op_a;
                    st_d.y    = op_b;
                    st_d.mode = ENG_RUN;
                end
            end
            ENG_RUN: begin
                if (st_q.y == '0) begin
                    st_d.mode = ENG_DONE;
                end else if (st_q.x < st_q.y) begin
                    st_d.x = st_q.y;
                    st_d.y = st_q.x;
                end else begin
                    st_d.x = st_q.x - st_q.y;
                end
            end
            ENG_DONE: begin
                if (take) st_d.mode = ENG_IDLE;
            end
            default: st_d.mode = ENG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.mode <= ENG_IDLE;
            st_q.x    <= '0;
            st_q.y    <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign free   = (st_q.mode == ENG_IDLE);
    assign done   = (st_q.mode == ENG_DONE);
    assign result = st_q.x;
endmodule

// File: rtl/gcd_order_arb.sv
module gcd_order_arb
    import gcd_dual_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic               resp_ready,
    input  logic [NUM_ENG-1:0] eng_free,
    input  logic [NUM_ENG-1:0] eng_done,
    output logic               req_ready,
    output logic               resp_valid,
    output logic [NUM_ENG-1:0] eng_start,
    output logic [NUM_ENG-1:0] eng_take,
    output logic               oldest
);
    arb_state_t st_d, st_q;
    logic       pick;
    logic       accept;
    logic       deliver;

    always_comb begin
        st_d       = st_q;
        req_ready  = |eng_free;
        resp_valid = eng_done[st_q.oldest];
        accept     = req_valid && req_ready;
        deliver    = resp_valid && resp_ready;
        if (&eng_free) pick = st_q.oldest;
        else           pick = eng_free[1];
        for (int i = 0; i < NUM_ENG; i++) begin
            eng_start[i] = accept && (pick == i[0]);
            eng_take[i]  = deliver && (st_q.oldest == i[0]);
        end
        if (deliver) st_d.oldest = ~st_q.oldest;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q.oldest <= 1'b0;
        else     st_q <= st_d;
    end

    assign oldest = st_q.oldest;
endmodule

// File: rtl/gcd_dual_top.sv
module gcd_dual_top
    import gcd_dual_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         req_valid,
    output logic         req_ready,
    input  logic [W-1:0] req_a,
    input  logic [W-1:0] req_b,
    output logic         resp_valid,
    input  logic         resp_ready,
    output logic [W-1:0] resp_gcd
);
    logic [NUM_ENG-1:0] eng_free;
    logic [NUM_ENG-1:0] eng_done;
    logic [NUM_ENG-1:0] eng_start;
    logic [NUM_ENG-1:0] eng_take;
    logic [W-1:0]       eng_res [NUM_ENG];
    logic               oldest;

    gcd_order_arb u_arb (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .resp_ready (resp_ready),
        .eng_free   (eng_free),
        .eng_done   (eng_done),
        .req_ready  (req_ready),
        .resp_valid (resp_valid),
        .eng_start  (eng_start),
        .eng_take   (eng_take),
        .oldest     (oldest)
    );

    for (genvar g = 0; g < NUM_ENG; g++) begin : g_eng
        gcd_engine #(.W(W)) u_eng (
            .clk    (clk),
            .rst    (rst),
            .start  (eng_start[g]),
            .take   (eng_take[g]),
            .op_a   (req_a),
            .op_b   (req_b),
            .free   (eng_free[g]),
            .done   (eng_done[g]),
            .result (eng_res[g])
        );
    end

    assign resp_gcd = eng_res[oldest];
endmodule

// File: rtl/gcd_dual_checker.sv
module gcd_dual_checker #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         req_valid,
    input logic         req_ready,
    input logic         resp_valid,
    input logic         resp_ready,
    input logic [W-1:0] resp_gcd,
    input logic         oldest
);
    logic [1:0] owed_q;

    always_ff @(posedge clk) begin
        if (rst) owed_q <= 2'd0;
        else owed_q <= owed_q + {1'b0, (req_valid && req_ready)}
                              - {1'b0, (resp_valid && resp_ready)};
    end

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!resp_valid && req_ready)); // R1
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        owed_q <= 2'd2); // R5
    AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (owed_q == 2'd2) |-> !req_ready); // R5
    AST_ONE_OWED_READY: assert property (@(posedge clk) disable iff (rst)
        (owed_q < 2'd2) |-> req_ready); // R4
    AST_VALID_HAS_JOB: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> (owed_q != 2'd0)); // R3
    AST_OLDEST_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_ready) |=> (oldest != $past(oldest))); // R3
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_gcd))); // R6
endmodule

bind gcd_dual_top gcd_dual_checker #(.W(W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .resp_valid (resp_valid),
    .resp_ready (resp_ready),
    .resp_gcd   (resp_gcd),
    .oldest     (oldest)
);

// File: tb/gcd_dual_top_bench.sv
module gcd_dual_top_bench;
    localparam int W       = 16;
    localparam int CLK_PER = 10;
    localparam int WDOG    = 150000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [W-1:0] req_a = '0;
    logic [W-1:0] req_b = '0;
    logic         resp_valid;
    logic         resp_ready = 1'b1;
    logic [W-1:0] resp_gcd;

    int           n_chk = 0;
    int           n_bad = 0;
    int           cyc   = 0;
    bit           finished = 0;
    logic [W-1:0] exp_q [$];
    string        tag_q [$];

    gcd_dual_top #(.W(W)) u_gcd_dual_top (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_a(req_a), .req_b(req_b),
        .resp_valid(resp_valid), .resp_ready(resp_ready),
        .resp_gcd(resp_gcd)
    );

    always #(CLK_PER/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [W-1:0] ref_gcd(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W-1:0] p = a;
        logic [W-1:0] q = b;
        logic [W-1:0] t;
        while (q != 0) begin
            t = p % q;
            p = q;
            q = t;
        end
        return p;
    endfunction

    task automatic check(input string req, input logic ok, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send(input logic [W-1:0] a, input logic [W-1:0] b, input string req);
        @(negedge clk);
        req_valid = 1'b1;
        req_a = a;
        req_b = b;
        while (!req_ready) @(negedge clk);
        exp_q.push_back(ref_gcd(a, b));
        tag_q.push_back(req);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // scoreboard monitor: compares each delivered result against the queue head
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (!rst && resp_valid && resp_ready) begin
                if (exp_q.size() == 0) begin
                    check("R3 unexpected response", 1'b0, int'(resp_gcd), -1);
                end else begin
                    logic [W-1:0] e;
                    string        t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(t, resp_gcd == e, int'(resp_gcd), int'(e));
                end
            end
        end
    end

    initial begin
        repeat (WDOG) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=<%0d", cyc, WDOG);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int t0;
        int spent;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 resp_valid after reset", resp_valid == 1'b0, int'(resp_valid), 0);
        check("R1 req_ready after reset", req_ready == 1'b1, int'(req_ready), 1);

        // R2: values including zero operands
        send(16'd48, 16'd18, "R2 gcd(48,18)");
        send(16'd17, 16'd5, "R2 gcd(17,5)");
        send(16'd0, 16'd9, "R2 gcd(0,9)");
        send(16'd21, 16'd0, "R2 gcd(21,0)");
        send(16'd0, 16'd0, "R2 gcd(0,0)");
        send(16'd100, 16'd75, "R2 gcd(100,75)");
        send(16'd7, 16'd7, "R2 gcd(7,7)");
        drain();

        // R3, R4, R5: slow job then fast job, third waits for the slow one
        send(16'd1000, 16'd1, "R3 slow first");
        check("R4 ready with one job owed", req_ready == 1'b1, int'(req_ready), 1);
        send(16'd6, 16'd4, "R3 fast second");
        check("R5 ready with two jobs owed", req_ready == 1'b0, int'(req_ready), 0);
        repeat (30) @(negedge clk);
        check("R3 fast result held back", resp_valid == 1'b0, int'(resp_valid), 0);
        check("R5 still blocked", req_ready == 1'b0, int'(req_ready), 0);
        send(16'd9, 16'd3, "R3 third after block");
        drain();

        // R6: stalled response holds steady
        resp_ready = 1'b0;
        send(16'd12, 16'd18, "R6 stalled gcd(12,18)");
        repeat (40) @(negedge clk);
        check("R6 valid under stall", resp_valid == 1'b1, int'(resp_valid), 1);
        check("R6 value under stall", resp_gcd == 16'd6, int'(resp_gcd), 6);
        repeat (5) @(negedge clk);
        check("R6 value still held", resp_valid && resp_gcd == 16'd6, int'(resp_gcd), 6);
        resp_ready = 1'b1;
        drain();

        // R7: throughput of eight long jobs
        t0 = cyc;
        for (int k = 0; k < 8; k++) send(16'(1000 + 2 * k), 16'd1, "R7 long job");
        drain();
        spent = cyc - t0;
        check("R7 burst cycles under 65% of single-engine work",
              spent * 100 < 8 * 1000 * 65, spent, 8 * 1000 * 65 / 100);
        check("R3 queue empty at end", exp_q.size() == 0, exp_q.size(), 0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule